// File: doc/BRIEF.md
# Linked-List DMA Segment Sequencer

This block drives a data mover from a list of transfer descriptors kept in memory. Software writes the address of the first descriptor, with two per-segment control bits in its low bits, into the current-pointer register, then issues a start command. The sequencer reads the descriptor over a single-beat read port and passes the segment to the mover. The segment's fields are the source address, the destination address and the byte count, plus the snoop attribute, which comes from the current pointer. The sequencer then waits for the mover's done pulse. Once a segment is retired, the descriptor's link word becomes the new current pointer, and the walk continues until a link word carries the last-segment flag.

A direct mode skips the fetch. It takes the source, destination and length from three programmed registers and runs a single segment. Two sticky status bits record segment completion and chain completion. The interrupt output stays high while either bit is set.

Register port, word offsets on `reg_addr`:
- 0 is control. Bit 0 is a start command and reads back as 0. Bit 1 selects direct mode. Bit 2 is the end-of-chain interrupt enable.
- 1 is status. Bit 0 is busy and is read-only. Bit 1 is segment done. Bit 2 is chain done. Bits 1 and 2 are write-one-to-clear.
- 2 is the current pointer. Bits 31:5 hold the address. Bit 4 is snoop. Bit 3 is the segment interrupt enable.
- 3 is the link word of the current descriptor and is read-only.
- 4 is the direct-mode source, 5 the direct-mode destination and 6 the direct-mode length.

A descriptor occupies 32 bytes:
- Byte 0 is the source address.
- Byte 4 is the destination address.
- Byte 8 is the link word, which carries the next pointer plus its bits 4 and 3, and bit 0 as the last-segment flag.
- Byte 12 holds the byte count in bits 15:0.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the current pointer reads 0, the status reads 0, and `busy`, `irq`, `mem_req` and `mv_req` are low.
- R2: Bits 2:0 of the current pointer always read 0. Bits 31:3 keep the value written while the channel is idle.
- R3: In chaining mode the block reads the words at pointer+0, +4, +8 and +12 (source, destination, link, length) and presents source, destination and length unchanged on the mover port. `mem_req` holds with a stable address until `mem_ack`.
- R4: When a segment is retired and the link word's bit 0 is clear, the pointer takes the link word with bits 2:0 cleared. `mv_snoop` equals bit 4 of the pointer for the whole segment.
- R5: A link word with bit 0 set ends the chain after its segment. No further descriptor is read.
- R6: When a chained segment finishes while pointer bit 3 is set, status bit 1 becomes 1.
- R7: When the chain or the direct segment finishes while control bit 2 is set, status bit 2 becomes 1. Otherwise it stays 0.
- R8: Writing 1 to status bit 1 or bit 2 clears only that bit. `irq` is high exactly while status bit 1 or bit 2 is set.
- R9: `busy` is high from start until the chain ends. A start command or a pointer write while busy has no effect.
- R10: A segment whose length is 0 is retired without raising `mv_req`, and still sets status bit 1 when pointer bit 3 is set.
- R11: In direct mode the block reads no memory. It hands the programmed source, destination and length, with snoop from pointer bit 4, to the mover, and does not set status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Descriptor word read data |
| mv_req | output | 1 | Segment request to the mover, held until done |
| mv_src | output | 32 | Segment source address |
| mv_dst | output | 32 | Segment destination address |
| mv_len | output | 16 | Segment byte count |
| mv_snoop | output | 1 | Snoop attribute for the segment |
| mv_done | input | 1 | Mover completion pulse |
| busy | output | 1 | Channel active |
| irq | output | 1 | Interrupt, OR of the sticky status bits |

## Verification
The hardest situations to reach from the ports involve the pointer shift across retirements. The control bits of the second and third segments must come from the previous link word, not from the software write. Zero-length segments must sit between real ones. The stimulus table builds chains of one to three descriptors in the bench memory, each with its own snoop and interrupt-enable bits and with zero lengths in the first and middle positions. After each chain the bench compares every mover request, the final pointer and the memory read count. A directed case writes a start command and a pointer value while a chain is running, then confirms that the read count, the move count and the final pointer are unchanged.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_XFER   = 2'd2,
        S_RETIRE = 2'd3
    } seq_state_e;

    // register word offsets
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_CUR  = 3'd2;
    localparam logic [2:0] RA_LINK = 3'd3;
    localparam logic [2:0] RA_SRC  = 3'd4;
    localparam logic [2:0] RA_DST  = 3'd5;
    localparam logic [2:0] RA_LEN  = 3'd6;

    // bit positions inside the pointer / link word
    localparam int PB_SNOOP = 4;
    localparam int PB_SEGIE = 3;
    localparam int PB_LAST  = 0;

    // descriptor word index of each field
    localparam logic [1:0] DW_SRC  = 2'd0;
    localparam logic [1:0] DW_DST  = 2'd1;
    localparam logic [1:0] DW_LINK = 2'd2;
    localparam logic [1:0] DW_LEN  = 2'd3;

endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    // towards the sequencer
    output logic          start,
    output logic          dir_mode,
    output logic          eot_ie,
    output logic [AW-1:0] dsrc,
    output logic [AW-1:0] ddst,
    output logic [LW-1:0] dlen,
    output logic          cur_wr,
    output logic [AW-1:3] cur_wval,
    output logic [1:0]    stat_clr,
    // readback from the sequencer
    input  logic          busy,
    input  logic          seg_done,
    input  logic          chain_done,
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] link_word
);

    typedef struct packed {
        logic          dir;
        logic          eot;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    r_d.dir = reg_wdata[1];
                    r_d.eot = reg_wdata[2];
                end
                RA_SRC: r_d.src = reg_wdata;
                RA_DST: r_d.dst = reg_wdata;
                RA_LEN: r_d.len = reg_wdata[LW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // a start command takes the mode bits written in the same access
    assign start    = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];
    assign dir_mode = (reg_wr && reg_addr == RA_CTRL) ? reg_wdata[1] : r_q.dir;
    assign eot_ie   = r_q.eot;
    assign dsrc     = r_q.src;
    assign ddst     = r_q.dst;
    assign dlen     = r_q.len;
    assign cur_wr   = reg_wr && (reg_addr == RA_CUR);
    assign cur_wval = reg_wdata[AW-1:3];
    assign stat_clr = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[2:1] : 2'b00;

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {{(AW-3){1'b0}}, r_q.eot, r_q.dir, 1'b0};
            RA_STAT: reg_rdata = {{(AW-3){1'b0}}, chain_done, seg_done, busy};
            RA_CUR:  reg_rdata = cur_ptr;
            RA_LINK: reg_rdata = link_word;
            RA_SRC:  reg_rdata = r_q.src;
            RA_DST:  reg_rdata = r_q.dst;
            RA_LEN:  reg_rdata = {{(AW-LW){1'b0}}, r_q.len};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_mode,
    input  logic          eot_ie,
    input  logic [AW-1:0] dsrc,
    input  logic [AW-1:0] ddst,
    input  logic [LW-1:0] dlen,
    input  logic          cur_wr,
    input  logic [AW-1:3] cur_wval,
    input  logic [1:0]    stat_clr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          mv_req,
    output logic [AW-1:0] mv_src,
    output logic [AW-1:0] mv_dst,
    output logic [LW-1:0] mv_len,
    output logic          mv_snoop,
    input  logic          mv_done,
    output logic          busy,
    output logic          seg_done,
    output logic          chain_done,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] link_word
);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] cur;
        logic [AW-1:0] link;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [1:0]    idx;
        logic          dir;
        logic          segf;
        logic          chf;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (stat_clr[0]) d.segf = 1'b0;
        if (stat_clr[1]) d.chf  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cur_wr) d.cur = {cur_wval, 3'b000};
                if (start) begin
                    d.dir = dir_mode;
                    d.idx = DW_SRC;
                    if (dir_mode) begin
                        d.src = dsrc;
                        d.dst = ddst;
                        d.len = dlen;
                        d.st  = (dlen == '0) ? S_RETIRE : S_XFER;
                    end else begin
                        d.st  = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (mem_ack) begin
                    case (q.idx)
                        DW_SRC:  d.src  = mem_rdata;
                        DW_DST:  d.dst  = mem_rdata;
                        DW_LINK: d.link = mem_rdata;
                        default: d.len  = mem_rdata[LW-1:0];
                    endcase
                    d.idx = 2'(q.idx + 2'd1);
                    if (q.idx == DW_LEN)
                        d.st = (mem_rdata[LW-1:0] == '0) ? S_RETIRE : S_XFER;
                end
            end
            S_XFER: begin
                if (mv_done) d.st = S_RETIRE;
            end
            default: begin // S_RETIRE
                if (!q.dir && q.cur[PB_SEGIE]) d.segf = 1'b1;
                if (q.dir || q.link[PB_LAST]) begin
                    d.st = S_IDLE;
                    if (eot_ie) d.chf = 1'b1;
                end else begin
                    d.cur = {q.link[AW-1:3], 3'b000};
                    d.idx = DW_SRC;
                    d.st  = S_FETCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req    = (q.st == S_FETCH);
    assign mem_addr   = {q.cur[AW-1:5], 1'b0, q.idx, 2'b00};
    assign mv_req     = (q.st == S_XFER);
    assign mv_src     = q.src;
    assign mv_dst     = q.dst;
    assign mv_len     = q.len;
    assign mv_snoop   = q.cur[PB_SNOOP];
    assign busy       = (q.st != S_IDLE);
    assign seg_done   = q.segf;
    assign chain_done = q.chf;
    assign cur_ptr    = q.cur;
    assign link_word  = q.link;

    // R3: a read request holds with a stable address until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R4: segment attributes hold while the mover works
    p_mv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req && !mv_done |=> mv_req && $stable(mv_snoop) && $stable(mv_src)
                               && $stable(mv_dst) && $stable(mv_len));

    // R9: the pointer does not move while a descriptor is fetched or moved
    p_cur_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FETCH || q.st == S_XFER) |=> $stable(q.cur));

    // R6: segment flag rises only when a segment is retired
    p_seg_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seg_done) |-> $past(q.st == S_RETIRE));

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          mv_req,
    output logic [AW-1:0] mv_src,
    output logic [AW-1:0] mv_dst,
    output logic [LW-1:0] mv_len,
    output logic          mv_snoop,
    input  logic          mv_done,
    output logic          busy,
    output logic          irq
);

    logic          start, dir_mode, eot_ie, cur_wr;
    logic [AW-1:0] dsrc, ddst, cur_ptr, link_word;
    logic [LW-1:0] dlen;
    logic [AW-1:3] cur_wval;
    logic [1:0]    stat_clr;
    logic          seg_done, chain_done;

    dcs_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .start      (start),
        .dir_mode   (dir_mode),
        .eot_ie     (eot_ie),
        .dsrc       (dsrc),
        .ddst       (ddst),
        .dlen       (dlen),
        .cur_wr     (cur_wr),
        .cur_wval   (cur_wval),
        .stat_clr   (stat_clr),
        .busy       (busy),
        .seg_done   (seg_done),
        .chain_done (chain_done),
        .cur_ptr    (cur_ptr),
        .link_word  (link_word)
    );

    dcs_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_mode   (dir_mode),
        .eot_ie     (eot_ie),
        .dsrc       (dsrc),
        .ddst       (ddst),
        .dlen       (dlen),
        .cur_wr     (cur_wr),
        .cur_wval   (cur_wval),
        .stat_clr   (stat_clr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mv_req     (mv_req),
        .mv_src     (mv_src),
        .mv_dst     (mv_dst),
        .mv_len     (mv_len),
        .mv_snoop   (mv_snoop),
        .mv_done    (mv_done),
        .busy       (busy),
        .seg_done   (seg_done),
        .chain_done (chain_done),
        .cur_ptr    (cur_ptr),
        .link_word  (link_word)
    );

    assign irq = seg_done | chain_done;

    // R9: fetch and move never overlap, and both only while busy
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mv_req) && ((mem_req || mv_req) -> busy));

    // R10: the mover never sees an empty segment
    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> mv_len != '0);

    // R8: the interrupt drops only after a software status write
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == RA_STAT));

endmodule

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_req;
    logic [31:0] mv_src, mv_dst;
    logic [15:0] mv_len;
    logic        mv_snoop;
    logic        mv_done = 1'b0;
    logic        busy, irq;

    always #5 clk = ~clk;

    dma_chain_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
        .mv_snoop(mv_snoop), .mv_done(mv_done), .busy(busy), .irq(irq)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory and mover models
    logic [31:0] mem [0:255];
    int          mem_reads = 0;
    logic [31:0] lg_src [0:7];
    logic [31:0] lg_dst [0:7];
    logic [15:0] lg_len [0:7];
    logic        lg_snp [0:7];
    int          moves = 0;
    int          wcnt = 0;

    initial forever begin
        @(negedge clk);
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[9:2]];
            mem_reads++;
        end
    end

    initial forever begin
        @(negedge clk);
        if (mv_done) mv_done = 1'b0;
        else if (mv_req) begin
            if (wcnt == 0 && moves < 8) begin
                lg_src[moves] = mv_src;
                lg_dst[moves] = mv_dst;
                lg_len[moves] = mv_len;
                lg_snp[moves] = mv_snoop;
            end
            wcnt++;
            if (wcnt == 3) begin
                mv_done = 1'b1;
                wcnt = 0;
                moves++;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    // stimulus table: ctl bits are {snoop, segment irq enable}
    typedef struct packed {
        logic [1:0]  n;
        logic [15:0] l0, l1, l2;
        logic [1:0]  c0, c1, c2;
        logic        eot;
        logic [1:0]  mv;
        logic        eos;
    } case_t;

    localparam case_t TBL [0:3] = '{
        '{n:2'd1, l0:16'h0040, l1:16'h0000, l2:16'h0000, c0:2'b01, c1:2'b00, c2:2'b00, eot:1'b1, mv:2'd1, eos:1'b1},
        '{n:2'd3, l0:16'h0010, l1:16'h0020, l2:16'h0030, c0:2'b10, c1:2'b00, c2:2'b11, eot:1'b0, mv:2'd3, eos:1'b1},
        '{n:2'd2, l0:16'h0000, l1:16'h0008, l2:16'h0000, c0:2'b01, c1:2'b10, c2:2'b00, eot:1'b1, mv:2'd1, eos:1'b1},
        '{n:2'd3, l0:16'h0004, l1:16'h0000, l2:16'h0100, c0:2'b00, c1:2'b00, c2:2'b00, eot:1'b1, mv:2'd2, eos:1'b0}
    };

    function automatic logic [15:0] t_len(case_t c, int i);
        return (i == 0) ? c.l0 : (i == 1) ? c.l1 : c.l2;
    endfunction

    function automatic logic [1:0] t_ctl(case_t c, int i);
        return (i == 0) ? c.c0 : (i == 1) ? c.c1 : c.c2;
    endfunction

    function automatic logic [31:0] d_addr(int i);
        return 32'h100 + 32'(32 * i);
    endfunction

    task automatic build(case_t c, int cs);
        for (int i = 0; i < int'(c.n); i++) begin
            mem[(d_addr(i) >> 2) + 0] = 32'h1000_0000 + 32'(cs * 256 + i * 16);
            mem[(d_addr(i) >> 2) + 1] = 32'h2000_0000 + 32'(cs * 256 + i * 16);
            mem[(d_addr(i) >> 2) + 2] = (i == int'(c.n) - 1) ? 32'h0000_0001
                                       : (d_addr(i + 1) | {27'd0, t_ctl(c, i + 1), 3'd0});
            mem[(d_addr(i) >> 2) + 3] = {16'hdead, t_len(c, i)};
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R9 watchdog: actual=busy expected=idle");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd2, v); chk("R1 pointer", v, 32'h0);
        rd(3'd1, v); chk("R1 status", v, 32'h0);
        chk("R1 outputs", {28'd0, busy, irq, mem_req, mv_req}, 32'h0);

        // R2: reserved pointer bits
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 reserved bits", v, 32'hFFFF_FFF8);

        // table walk: R3 R4 R5 R6 R7 R8 R10
        for (int cs = 0; cs < 4; cs++) begin
            case_t c;
            int k;
            c = TBL[cs];
            build(c, cs);
            mem_reads = 0; moves = 0;
            wr(3'd2, d_addr(0) | {27'd0, c.c0, 3'd0});
            wr(3'd0, {29'd0, c.eot, 1'b0, 1'b1});
            wait_idle();
            chk("R5 descriptor reads", 32'(mem_reads), 32'(4 * int'(c.n)));
            chk("R10 mover count", 32'(moves), 32'(c.mv));
            k = 0;
            for (int i = 0; i < int'(c.n); i++) begin
                if (t_len(c, i) != 16'h0 && k < 8) begin
                    chk("R3 src", lg_src[k], 32'h1000_0000 + 32'(cs * 256 + i * 16));
                    chk("R3 dst", lg_dst[k], 32'h2000_0000 + 32'(cs * 256 + i * 16));
                    chk("R3 len", {16'd0, lg_len[k]}, {16'd0, t_len(c, i)});
                    chk("R4 snoop", {31'd0, lg_snp[k]}, {31'd0, t_ctl(c, i)[1]});
                    k++;
                end
            end
            rd(3'd2, v);
            chk("R4 final pointer", v, d_addr(int'(c.n) - 1) | {27'd0, t_ctl(c, int'(c.n) - 1), 3'd0});
            rd(3'd1, v);
            chk("R6 segment flag", {31'd0, v[1]}, {31'd0, c.eos});
            chk("R7 chain flag", {31'd0, v[2]}, {31'd0, c.eot});
            chk("R8 irq level", {31'd0, irq}, {31'd0, c.eos | c.eot});
            wr(3'd1, 32'h6);
            rd(3'd1, v); chk("R8 cleared", v, 32'h0);
            chk("R8 irq low", {31'd0, irq}, 32'h0);
        end

        // R9: start and pointer write while busy are ignored
        build(TBL[1], 7);
        mem[(d_addr(1) >> 2) + 2] = 32'h1;
        mem_reads = 0; moves = 0;
        wr(3'd2, d_addr(0));
        wr(3'd0, 32'h1);
        chk("R9 busy after start", {31'd0, busy}, 32'h1);
        repeat (3) @(negedge clk);
        wr(3'd0, 32'h1);
        wr(3'd2, 32'h0000_0F00);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R9 reads unchanged", 32'(mem_reads), 32'd8);
        chk("R9 moves unchanged", 32'(moves), 32'd2);
        chk("R9 idle", {31'd0, busy}, 32'h0);
        rd(3'd2, v); chk("R9 pointer kept", v, d_addr(1));

        // R11: direct mode, with pointer bits 4 and 3 set
        mem_reads = 0; moves = 0;
        wr(3'd4, 32'hAAAA_0000);
        wr(3'd5, 32'hBBBB_0000);
        wr(3'd6, 32'h0000_0123);
        wr(3'd2, 32'h0000_0218);
        wr(3'd0, 32'h7);
        wait_idle();
        chk("R11 no reads", 32'(mem_reads), 32'd0);
        chk("R11 one move", 32'(moves), 32'd1);
        chk("R11 src", lg_src[0], 32'hAAAA_0000);
        chk("R11 dst", lg_dst[0], 32'hBBBB_0000);
        chk("R11 len", {16'd0, lg_len[0]}, 32'h123);
        chk("R11 snoop", {31'd0, lg_snp[0]}, 32'h1);
        rd(3'd1, v); chk("R11 status", v, 32'h4);

        // R8: partial clear keeps the other flag
        wr(3'd1, 32'h2);
        rd(3'd1, v); chk("R8 partial clear", v, 32'h4);
        chk("R8 irq held", {31'd0, irq}, 32'h1);
        wr(3'd1, 32'h4);
        chk("R8 irq drop", {31'd0, irq}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule